// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address. It walks a three-level translation table held in memory. A request is accepted with a valid/ready handshake, together with the address of the root table. The walker then issues three dependent 32-bit reads, one at a time, over a simple request/response memory port. It returns either the physical address or a fault that names the level where the walk stopped.

The root table holds four entries. It is indexed by the top two address bits. The inner tables hold 512 entries each and take 2 KB of storage. They may start at any 2 KB boundary, so they need not sit on a page boundary. An entry in the first or second level carries a 25-bit pointer to the next table. An entry in the third level carries a 24-bit frame number. Bit 0 of every entry marks it present.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, and both `mem_req_valid` and `done_valid` are 0.
- R2: The first read goes to `{root_base[35:4], vaddr[31:30], 2'b00}`. Bits 3..0 of `root_base` have no effect on it.
- R3: The second read goes to `{E1[31:7], vaddr[29:21], 2'b00}`, where E1 is the first-level entry. The pointer selects a 2 KB block, so a table at an odd 2 KB boundary is reached correctly.
- R4: The third read goes to `{E2[31:7], vaddr[20:12], 2'b00}`, where E2 is the second-level entry.
- R5: On success `done_paddr` is `{E3[31:8], vaddr[11:0]}`, where E3 is the third-level entry. Bits 7..1 of E3 have no effect on the result, and neither have bits 6..1 of E1 or E2.
- R6: An entry with bit 0 clear ends the walk with `done_fault` set to 1, `done_level` set to that level (1, 2 or 3) and `done_paddr` set to 0. No further read is issued. On success `done_fault` is 0 and `done_level` is 0.
- R7: Once `mem_req_valid` is raised, it and `mem_req_addr` stay unchanged until a cycle in which `mem_req_ready` is 1.
- R8: Responses may come any number of cycles after a read is accepted. At most one read is outstanding, the reads go out in level order, and every read address is word aligned.
- R9: `req_ready` is 0 from the cycle after a request is taken until the result. A `req_valid` seen during that time is ignored. `done_valid` is a one-cycle pulse that comes the cycle after the deciding response, and `req_ready` returns to 1 in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 36 | Physical address of the root table (16-byte aligned) |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read this cycle |
| mem_req_addr | output | 36 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry returned by memory |
| done_valid | output | 1 | One-cycle result strobe |
| done_paddr | output | 36 | Translated physical address, 0 on fault |
| done_fault | output | 1 | Walk ended on an entry that is not present |
| done_level | output | 2 | Level that faulted (1 to 3), 0 on success |

## Verification
If the walk state goes wrong, it shows at the memory port on the very next read. The read goes to the wrong address, comes at the wrong level, or fails to appear at all. The bench therefore logs and compares every read address, not just the final result. A wrong fault or level decision shows up as a wrong read count, and in the one `done_valid` cycle that follows the deciding response. A lost or repeated state shows as `req_ready` rising early during a walk, or as a missing or repeated result pulse, within a cycle or two.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic [35:0] root_base,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [35:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        done_valid,
  output logic [35:0] done_paddr,
  output logic        done_fault,
  output logic [1:0]  done_level
);

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_L3_REQ, S_L3_WAIT, S_DONE
  } walk_st_t;

  walk_st_t    st;
  logic [31:0] va_q;
  logic [35:0] addr_q;
  logic [35:0] pa_q;
  logic        fault_q;
  logic [1:0]  level_q;

  logic present;
  logic unused_bits;
  assign present     = mem_rsp_data[0];
  assign unused_bits = ^{mem_rsp_data[6:1], root_base[3:0]};

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_L1_REQ) || (st == S_L2_REQ) || (st == S_L3_REQ);
  assign mem_req_addr  = addr_q;
  assign done_valid    = (st == S_DONE);
  assign done_paddr    = pa_q;
  assign done_fault    = fault_q;
  assign done_level    = level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      pa_q    <= '0;
      fault_q <= 1'b0;
      level_q <= 2'd0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          addr_q  <= {root_base[35:4], req_vaddr[31:30], 2'b00};
          pa_q    <= '0;
          fault_q <= 1'b0;
          level_q <= 2'd0;
          st      <= S_L1_REQ;
        end
        S_L1_REQ: if (mem_req_ready) st <= S_L1_WAIT;
        S_L2_REQ: if (mem_req_ready) st <= S_L2_WAIT;
        S_L3_REQ: if (mem_req_ready) st <= S_L3_WAIT;
        S_L1_WAIT: if (mem_rsp_valid) begin
          if (!present) begin
            fault_q <= 1'b1;
            level_q <= 2'd1;
            st      <= S_DONE;
          end else begin
            addr_q <= {mem_rsp_data[31:7], va_q[29:21], 2'b00};
            st     <= S_L2_REQ;
          end
        end
        S_L2_WAIT: if (mem_rsp_valid) begin
          if (!present) begin
            fault_q <= 1'b1;
            level_q <= 2'd2;
            st      <= S_DONE;
          end else begin
            addr_q <= {mem_rsp_data[31:7], va_q[20:12], 2'b00};
            st     <= S_L3_REQ;
          end
        end
        S_L3_WAIT: if (mem_rsp_valid) begin
          if (!present) begin
            fault_q <= 1'b1;
            level_q <= 2'd3;
          end else begin
            pa_q <= {mem_rsp_data[31:8], va_q[11:0]};
          end
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7: a stalled read keeps its address
  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R8: entry reads are word aligned
  a_r8_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

  // R9: no new request is taken while a read is in flight
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R9: result is a single-cycle pulse followed by idle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && req_ready);

  // R6: a fault always names a level and carries no address
  a_r6_fault_level: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_fault |-> done_level != 2'd0 && done_paddr == '0);

  // R6: a success reports level zero
  a_r6_ok_level: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_fault |-> done_level == 2'd0);

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [35:0] root_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [35:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done_valid;
  logic [35:0] done_paddr;
  logic        done_fault;
  logic [1:0]  done_level;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .root_base(root_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_paddr(done_paddr),
    .done_fault(done_fault), .done_level(done_level)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] mem [logic [35:0]];
  int          cfg_lat = 0;
  int          cfg_rdly = 0;
  int          nreq = 0;
  logic [35:0] rlog [4];

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(logic [35:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  // memory model: stalls acceptance by cfg_rdly cycles, answers after cfg_lat cycles
  initial begin
    bit          pend = 0;
    int          wcnt = 0;
    int          stall = 0;
    logic [35:0] qaddr = '0;
    logic [35:0] saddr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'b0;
      if (!rst_n) begin
        pend = 0; stall = 0;
      end else if (pend) begin
        if (wcnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(qaddr);
          pend = 0;
        end else wcnt--;
      end else if (mem_req_valid) begin
        if (stall > 0)
          chk(mem_req_addr == saddr, "R7 address held while stalled", mem_req_addr, saddr);
        else
          saddr = mem_req_addr;
        if (stall < cfg_rdly) stall++;
        else begin
          mem_req_ready = 1'b1;
          stall = 0;
          pend = 1;
          qaddr = mem_req_addr;
          wcnt = cfg_lat;
          if (nreq < 4) rlog[nreq] = mem_req_addr;
          nreq++;
        end
      end
    end
  end

  // build a three-level path; pmask bit i clear makes level i+1 absent
  task automatic run_walk(string name, logic [31:0] va, logic [35:0] root,
                          logic [24:0] p2, logic [24:0] p3, logic [23:0] frame,
                          logic [2:0] pmask, logic [6:0] fl, int lat, int rdly);
    logic [35:0] a1, a2, a3, exp_pa;
    int          exp_lvl, cyc;
    bit          busy_ok;
    mem.delete();
    a1 = {root[35:4], va[31:30], 2'b00};
    a2 = {p2, va[29:21], 2'b00};
    a3 = {p3, va[20:12], 2'b00};
    mem[a1] = {p2, fl[5:0], pmask[0]};
    mem[a2] = {p3, fl[5:0], pmask[1]};
    mem[a3] = {frame, fl, pmask[2]};
    exp_lvl = !pmask[0] ? 1 : !pmask[1] ? 2 : !pmask[2] ? 3 : 0;
    exp_pa  = (exp_lvl == 0) ? {frame, va[11:0]} : 36'h0;
    cfg_lat = lat; cfg_rdly = rdly; nreq = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; root_base = root;
    @(negedge clk);
    req_vaddr = ~va;
    root_base = ~root;
    busy_ok = 1; cyc = 0;
    while (!done_valid && cyc < 2000) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    chk(busy_ok, {name, " R9 ready low during walk"}, 0, 1);
    chk(done_valid, {name, " R9 result arrives"}, done_valid, 1);
    chk(done_fault == (exp_lvl != 0), {name, " R6 fault flag"}, done_fault, exp_lvl != 0);
    chk(done_level == exp_lvl[1:0], {name, " R6 fault level"}, done_level, exp_lvl);
    chk(done_paddr == exp_pa, {name, " R5 physical address"}, done_paddr, exp_pa);
    chk(nreq == (exp_lvl == 0 ? 3 : exp_lvl), {name, " R8 read count"}, nreq, exp_lvl == 0 ? 3 : exp_lvl);
    chk(rlog[0] == a1, {name, " R2 level-1 address"}, rlog[0], a1);
    if (nreq >= 2) chk(rlog[1] == a2, {name, " R3 level-2 address"}, rlog[1], a2);
    if (nreq >= 3) chk(rlog[2] == a3, {name, " R4 level-3 address"}, rlog[2], a3);
    @(negedge clk);
    chk(!done_valid && req_ready, {name, " R9 pulse ends, ready back"}, {done_valid, req_ready}, 2'b01);
    chk(!mem_req_valid, {name, " R9 stray request ignored"}, mem_req_valid, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(mem_req_valid == 1'b0, "R1 no read after reset", mem_req_valid, 0);
    chk(done_valid == 1'b0, "R1 no result after reset", done_valid, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_basic();
    run_walk("basic", 32'h4123_4567, 36'h0_0001_0000, 25'h000_0123, 25'h1AB_CDEF,
             24'hABC_DEF, 3'b111, 7'h00, 0, 0);
  endtask

  task automatic t_slow_memory();
    run_walk("slow", 32'h8765_4321, 36'h0_0002_0040, 25'h0F0_0001, 25'h000_0003,
             24'h123_456, 3'b111, 7'h00, 4, 3);
  endtask

  task automatic t_root_low_bits_and_flags();
    run_walk("flags", 32'hC0FF_EFFF, 36'h9_8765_432F, 25'h1FF_FFFF, 25'h155_5555,
             24'hFED_CBA, 3'b111, 7'h7F, 1, 1);
  endtask

  task automatic t_faults();
    run_walk("fault1", 32'h0000_0000, 36'h0_0000_1000, 25'h000_0011, 25'h000_0022,
             24'h000_033, 3'b110, 7'h2A, 2, 0);
    run_walk("fault2", 32'h7FFF_F000, 36'h0_0000_2000, 25'h0AA_0001, 25'h055_0001,
             24'h777_777, 3'b101, 7'h15, 0, 2);
    run_walk("fault3", 32'hBEEF_0ABC, 36'h0_0000_3000, 25'h033_3333, 25'h044_4445,
             24'h888_888, 3'b011, 7'h7E, 3, 1);
  endtask

  task automatic t_max_indices();
    run_walk("maxidx", 32'hFFFF_FFFF, 36'hF_FFFF_FFF0, 25'h000_0001, 25'h100_0000,
             24'hFFF_FFF, 3'b111, 7'h00, 0, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_slow_memory();
    t_root_low_bits_and_flags();
    t_faults();
    t_max_indices();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #3000000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule